// File: doc/BRIEF.md
# External interrupt sensitivity controller

This block turns activity on two groups of external pins into one interrupt request for each group. A group can be set to react to rising edges, falling edges, or both. It can also use a combined mode, where a falling edge is latched and the request also stays asserted while any pin of the group is held low. Each pin passes through a two-flop synchronizer. The edge events of all pins in a group are OR-combined.

Software sets the sensitivity through one 8-bit control register. The two 2-bit sensitivity fields take a new value only while both CPU interrupt mask bits are set. This stops a mode change from producing a spurious request while interrupts are live. The other bits of the register are always writable. Bit 5 drives a clock-output enable. Bits 2:0 are stored and read back with no other effect. A latched edge request stays pending until the interrupt handler pulses that group's acknowledge input.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, both requests are low and the clock-output enable is low, given pins held high.
- R2: The group 1 sensitivity code sits in register bits 7:6 and the group 0 code in bits 4:3. Group 0 watches `pins_a` and group 1 watches `pins_b`.
- R3: A write changes bits 7:6 and 4:3 only when `cpu_mask` is 2'b11. Otherwise those bits keep their previous value.
- R4: A write always updates bits 5 and 2:0. All 8 bits read back on `rd_data`, and bit 5 drives `clkout_en`.
- R5: With code 1, a rising edge on any pin of the group sets that group's request, and a falling edge does not.
- R6: With code 2, a falling edge on any pin of the group sets the request, and a rising edge does not.
- R7: With code 3, either edge on any pin of the group sets the request.
- R8: With code 0, a falling edge sets the request. The request also stays high for as long as any pin in the group is low, even after an acknowledge.
- R9: A latched request stays high until `ack` for its group is 1 at a clock edge, and it clears at that edge. If a new edge event arrives in the same cycle as the acknowledge, the request stays set.
- R10: Activity on one group never raises the other group's request.
- R11: A pin change reaches `irq` no earlier than the second and no later than the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_a | input | PIN_W | Group 0 external pins (asynchronous) |
| pins_b | input | PIN_W | Group 1 external pins (asynchronous) |
| cpu_mask | input | 2 | CPU interrupt mask bits; 2'b11 unlocks the sensitivity fields |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| ack | input | 2 | Per-group request acknowledge (bit 0 = group 0) |
| rd_data | output | 8 | Register readback |
| irq | output | 2 | Per-group interrupt request (bit 0 = group 0) |
| clkout_en | output | 1 | Clock-output enable (register bit 5) |

## Verification
Two functions can meet in the same cycle: an acknowledge that clears a pending request, and a fresh edge event that sets it. The bench holds `ack` high across a rising edge in code 1. The event then reaches the pending flop in the same cycle that the acknowledge is seen. The bench samples `irq` just after that edge and expects it high, because setting takes priority. It also expects the request to fall one edge later, once only the acknowledge remains. A second overlap comes from the level term in code 0, which must keep `irq` high through an acknowledge.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    SENS_FALL_LOW = 2'd0,
    SENS_RISE     = 2'd1,
    SENS_FALL     = 2'd2,
    SENS_BOTH     = 2'd3
  } sens_t;

  localparam int unsigned CFG_W      = 8;
  localparam int unsigned G1_LSB     = 6;
  localparam int unsigned G0_LSB     = 3;
  localparam int unsigned CLKOUT_BIT = 5;
  localparam int unsigned N_GROUPS   = 2;
endpackage

// File: rtl/extint_rst_sync.sv
module extint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/extint_cfg_reg.sv
module extint_cfg_reg
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [1:0]       cpu_mask,
  output logic [CFG_W-1:0] cfg_q,
  output sens_t            mode_g0,
  output sens_t            mode_g1
);
  localparam logic [CFG_W-1:0] LOCKED_MASK =
    (CFG_W'(2'b11) << G1_LSB) | (CFG_W'(2'b11) << G0_LSB);

  logic             unlocked;
  logic [CFG_W-1:0] wr_mask;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    unlocked = (cpu_mask == 2'b11);
    wr_mask  = unlocked ? '1 : ~LOCKED_MASK;
    cfg_d    = cfg_q;
    if (wr_en) cfg_d = (cfg_q & ~wr_mask) | (wr_data & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign mode_g0 = sens_t'(cfg_q[G0_LSB +: 2]);
  assign mode_g1 = sens_t'(cfg_q[G1_LSB +: 2]);

  // R3: locked fields hold while the mask is not fully set
  a_r3_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mask != 2'b11) |=> ($stable(cfg_q[G1_LSB +: 2]) && $stable(cfg_q[G0_LSB +: 2])));

  // R4: free bits always follow a write
  a_r4_free_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[CLKOUT_BIT] == $past(wr_data[CLKOUT_BIT]))
              && (cfg_q[2:0] == $past(wr_data[2:0])));
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins_sync,
  input  sens_t            mode,
  input  logic             ack,
  output logic             irq
);
  logic [PIN_W-1:0] prev_q;
  logic             pend_q;
  logic             pend_d;
  logic             rise_any;
  logic             fall_any;
  logic             low_any;
  logic             evt;

  always_comb begin
    rise_any = |(pins_sync & ~prev_q);
    fall_any = |(~pins_sync & prev_q);
    low_any  = |(~pins_sync);
    unique case (mode)
      SENS_FALL_LOW: evt = fall_any;
      SENS_RISE:     evt = rise_any;
      SENS_FALL:     evt = fall_any;
      default:       evt = rise_any | fall_any;
    endcase
    pend_d = evt | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pins_sync;
      pend_q <= pend_d;
    end
  end

  assign irq = pend_q | ((mode == SENS_FALL_LOW) & low_any);

  // R9: pending persists without acknowledge
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);

  // R9: acknowledge without a new event clears
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rise_any && !fall_any) |=> !pend_q);

  // R5: a rising edge in rising mode sets pending
  a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENS_RISE && rise_any) |=> pend_q);

  // R6: falling-only mode ignores rising edges
  a_r6_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENS_FALL && !fall_any && !pend_q) |=> !pend_q);
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins_a,
  input  logic [PIN_W-1:0] pins_b,
  input  logic [1:0]       cpu_mask,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       ack,
  output logic [7:0]       rd_data,
  output logic [1:0]       irq,
  output logic             clkout_en
);
  logic                              rst_n_s;
  logic [CFG_W-1:0]                  cfg_q;
  sens_t                             mode_g0;
  sens_t                             mode_g1;
  sens_t [N_GROUPS-1:0]              grp_mode;
  logic  [N_GROUPS-1:0][PIN_W-1:0]   grp_pins;

  extint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  extint_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cpu_mask (cpu_mask),
    .cfg_q    (cfg_q),
    .mode_g0  (mode_g0),
    .mode_g1  (mode_g1)
  );

  assign grp_mode[0] = mode_g0;
  assign grp_mode[1] = mode_g1;
  assign grp_pins[0] = pins_a;
  assign grp_pins[1] = pins_b;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    logic [PIN_W-1:0] pins_s;

    extint_sync #(.WIDTH(PIN_W)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .d_async (grp_pins[g]),
      .q_sync  (pins_s)
    );

    extint_detect #(.PIN_W(PIN_W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .pins_sync (pins_s),
      .mode      (grp_mode[g]),
      .ack       (ack[g]),
      .irq       (irq[g])
    );
  end

  assign rd_data   = cfg_q;
  assign clkout_en = cfg_q[CLKOUT_BIT];

  // R1: register is clear on the first cycle out of reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n_s) |-> (rd_data == 8'h00));
endmodule

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
  localparam int PW = 8;
  localparam int NV = 12;
  // {mode[7:6], grp[5], rise[4], idx[3:1], exp[0]}
  localparam logic [7:0] VEC [NV] = '{
    {2'd1,1'b0,1'b1,3'd0,1'b1}, {2'd1,1'b0,1'b0,3'd3,1'b0},
    {2'd2,1'b0,1'b0,3'd5,1'b1}, {2'd2,1'b0,1'b1,3'd7,1'b0},
    {2'd3,1'b0,1'b1,3'd2,1'b1}, {2'd3,1'b0,1'b0,3'd6,1'b1},
    {2'd0,1'b0,1'b0,3'd1,1'b1}, {2'd0,1'b0,1'b1,3'd4,1'b0},
    {2'd1,1'b1,1'b1,3'd7,1'b1}, {2'd2,1'b1,1'b1,3'd0,1'b0},
    {2'd3,1'b1,1'b0,3'd5,1'b1}, {2'd0,1'b1,1'b0,3'd3,1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [PW-1:0] pins_a, pins_b;
  logic [1:0] cpu_mask, ack, irq;
  logic wr_en, clkout_en;
  logic [7:0] wr_data, rd_data;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  extint_ctrl #(.PIN_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .pins_b(pins_b),
    .cpu_mask(cpu_mask), .wr_en(wr_en), .wr_data(wr_data), .ack(ack),
    .rd_data(rd_data), .irq(irq), .clkout_en(clkout_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] m, input logic [7:0] d);
    @(negedge clk);
    cpu_mask = m; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack_both();
    @(negedge clk);
    ack = 2'b11;
    @(negedge clk);
    ack = 2'b00;
  endtask

  task automatic set_pin(input logic g, input int idx, input logic v);
    if (g) pins_b[idx] = v; else pins_a[idx] = v;
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'd0: return "R8";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins_a = '1; pins_b = '1; cpu_mask = 2'b00;
    ack = 2'b00; wr_en = 1'b0; wr_data = 8'h00;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq", {6'd0, irq}, 8'h00);
    check("R1 clkout_en", {7'd0, clkout_en}, 8'h00);

    // Vector table: modes, groups, edges
    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      logic g, rise, e;
      int idx;
      m = VEC[i][7:6]; g = VEC[i][5]; rise = VEC[i][4];
      idx = int'(VEC[i][3:1]); e = VEC[i][0];
      // R2: field of the tested group, other group set to rising
      wr(2'b11, g ? {m, 1'b0, 2'b01, 3'b000} : {2'b01, 1'b0, m, 3'b000});
      set_pin(g, idx, ~rise);
      cycles(6);
      ack_both();
      cycles(2);
      set_pin(g, idx, rise);
      cycles(5);
      check($sformatf("%s R2 vec%0d", mode_req(m), i), {7'd0, irq[g]}, {7'd0, e});
      check($sformatf("R10 vec%0d", i), {7'd0, irq[~g]}, 8'h00);
      pins_a = '1; pins_b = '1;
      cycles(6);
      ack_both();
      cycles(2);
    end

    // R3/R4: locked write only changes free bits
    wr(2'b11, 8'h00);
    wr(2'b01, 8'hFF);
    check("R3 R4 locked write", rd_data, 8'h27);
    check("R4 clkout_en", {7'd0, clkout_en}, 8'h01);
    wr(2'b10, 8'h00);
    check("R3 R4 locked clear", rd_data, 8'h00);
    wr(2'b11, 8'hD8);
    check("R2 R3 unlocked write", rd_data, 8'hD8);

    // R11 latency: rising edge, group 0 code 1
    wr(2'b11, 8'h08);
    ack_both();
    cycles(2);
    pins_a[2] = 1'b0;
    cycles(6);
    ack_both();
    cycles(2);
    pins_a[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 after one edge", {7'd0, irq[0]}, 8'h00);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 after three edges", {7'd0, irq[0]}, 8'h01);

    // R9 hold without acknowledge, then single-cycle clear
    cycles(10);
    check("R9 hold", {7'd0, irq[0]}, 8'h01);
    ack_both();
    check("R9 clear", {7'd0, irq[0]}, 8'h00);

    // R9 event coinciding with acknowledge
    pins_a[4] = 1'b0;
    cycles(6);
    ack = 2'b01;
    @(negedge clk);
    pins_a[4] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 set wins over ack", {7'd0, irq[0]}, 8'h01);
    @(negedge clk);
    check("R9 ack clears after event", {7'd0, irq[0]}, 8'h00);
    ack = 2'b00;

    // R8 level persists through acknowledge
    wr(2'b11, 8'h00);
    pins_b[6] = 1'b0;
    cycles(5);
    ack_both();
    cycles(2);
    check("R8 level after ack", {7'd0, irq[1]}, 8'h01);
    pins_b[6] = 1'b1;
    cycles(5);
    ack_both();
    check("R8 level released", {7'd0, irq[1]}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule